// File: doc/BRIEF.md
# Salsa20 Core with Lane-Parallel Rounds

This block evaluates the Salsa20 core function on a sixteen-word state of 32-bit words. The caller presents the state already rearranged so that each of four registered rows holds one word from each column of the natural matrix. In that layout, one lane-parallel quarterround step updates a whole row at once. The caller also gives an even round count and pulses `start`.

The block then runs double rounds, made of a column half and a row half. One XOR-rotate update across all four lanes is done per clock cycle. The row half reuses the same four-lane datapath by reading rows at rotated lane offsets, and writes each update back at the inverse offset. When the round count is used up, every working word is added to the word that was loaded. The sum is put back into natural order, stored in the output register, and signalled with a one-cycle `done`.

An odd or zero round count is refused at `start` with a one-cycle `err` pulse, and no rounds are run.

Top module: `salsa_lane_core`

## Requirements
- R1: Input slot s = 4*row + lane lies on `blk_in[s*32 +: 32]`. Row 0 lane j holds natural word (5j mod 16), row 1 holds (5j+4) mod 16, row 2 holds (5j+8) mod 16, and row 3 holds (5j+12) mod 16.
- R2: On completion, `blk_out[n*32 +: 32]` holds natural word n of the Salsa20 core result. That result is the state after the given rounds plus the loaded state, added word by word modulo 2^32.
- R3: Each double round applies a column round and then a row round. The quarterround order is: y1 ^= rotl(y0+y3,7), y2 ^= rotl(y1+y0,9), y3 ^= rotl(y2+y1,13), y0 ^= rotl(y3+y2,18). The result matches the reference for 2, 8, 12 and 20 rounds.
- R4: For an accepted start with round count N, `done` is high in the cycle that follows the (4N+1)-th rising edge after the edge that sampled `start`.
- R5: `busy` is high from the edge that accepts `start` until the edge that raises `done`, and low whenever `done` is high.
- R6: A `start` pulse while `busy` is high is ignored: the running computation finishes with the result for its original input and round count.
- R7: A `start` with round count zero or odd raises `err` for exactly one cycle. `busy` stays low, no `done` follows, and `blk_out` is unchanged.
- R8: `done` lasts one cycle, and `blk_out` keeps its value until the next completion.
- R9: A synchronous active-high `rst` clears `busy`, `done`, `err` and `blk_out` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a computation |
| rounds_in | input | RW (8) | Round count, must be even and nonzero |
| blk_in | input | 512 | Input state in lane-permuted order (R1) |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | One-cycle strobe for a refused round count |
| blk_out | output | 512 | Result in natural word order |

## Verification
Any wrong word in the working rows spreads through the additions and rotations of the next steps. Within one double round it corrupts every lane, so any fault in a step or a lane offset shows up as a totally different `blk_out` at the `done` cycle. Counter faults show at the ports sooner: a wrong step or round counter moves `done` off its predicted cycle, and the bench checks `busy` and `done` on every cycle of a run. A faulty accept test shows as a missing or extra `err` pulse in the cycle right after `start`.

// File: rtl/salsa_pkg.sv
package salsa_pkg;
  localparam int WORD_W  = 32;
  localparam int LANES   = 4;
  localparam int ROWS    = 4;
  localparam int ROW_W   = WORD_W * LANES;
  localparam int STATE_W = ROW_W * ROWS;

  typedef logic [LANES-1:0][WORD_W-1:0] row_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} state_t;

  function automatic logic [WORD_W-1:0] rotl32(input logic [WORD_W-1:0] v, input int n);
    return (v << n) | (v >> (WORD_W - n));
  endfunction

  // out[j] = v[(j+k) mod LANES]
  function automatic row_t lane_rot(input row_t v, input int k);
    row_t o;
    for (int j = 0; j < LANES; j++) o[j] = v[(j + k) % LANES];
    return o;
  endfunction
endpackage

// File: rtl/salsa_qr_lanes.sv
module salsa_qr_lanes
  import salsa_pkg::*;
(
  input  row_t       p,
  input  row_t       q,
  input  row_t       r,
  input  row_t       s,
  input  logic [1:0] sub,
  output row_t       upd
);
  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      case (sub)
        2'd0:    upd[j] = q[j] ^ rotl32(p[j] + s[j], 7);
        2'd1:    upd[j] = r[j] ^ rotl32(q[j] + p[j], 9);
        2'd2:    upd[j] = s[j] ^ rotl32(r[j] + q[j], 13);
        default: upd[j] = p[j] ^ rotl32(s[j] + r[j], 18);
      endcase
    end
  end
endmodule

// File: rtl/salsa_unperm.sv
module salsa_unperm
  import salsa_pkg::*;
(
  input  row_t [ROWS-1:0]      rows,
  output logic [STATE_W-1:0]   nat
);
  localparam int NWORDS = ROWS * LANES;
  for (genvar rr = 0; rr < ROWS; rr++) begin : g_row
    for (genvar jj = 0; jj < LANES; jj++) begin : g_lane
      localparam int IDX = (5 * jj + 4 * rr) % NWORDS;
      assign nat[IDX*WORD_W +: WORD_W] = rows[rr][jj];
    end
  end
endmodule

// File: rtl/salsa_lane_core.sv
module salsa_lane_core
  import salsa_pkg::*;
#(
  parameter int RW = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [RW-1:0]      rounds_in,
  input  logic [STATE_W-1:0] blk_in,
  output logic               busy,
  output logic               done,
  output logic               err,
  output logic [STATE_W-1:0] blk_out
);
  localparam int STEPS = 8;
  localparam int SW    = $clog2(STEPS);

  state_t         st;
  logic [SW-1:0]  stp;
  logic [RW-1:0]  rem;
  row_t [ROWS-1:0] wk;
  row_t [ROWS-1:0] orig;
  row_t [ROWS-1:0] sum;
  row_t           p, q, r, s, upd;
  logic           row_half;
  logic [1:0]     sub;
  logic           cnt_ok;
  logic [STATE_W-1:0] nat;

  assign row_half = stp[SW-1];
  assign sub      = stp[1:0];
  assign cnt_ok   = (rounds_in != '0) && !rounds_in[0];

  // Row half reads rows b, c, d at lane offsets 3, 2, 1 with b/d roles swapped.
  always_comb begin
    p = wk[0];
    q = row_half ? lane_rot(wk[3], 1) : wk[1];
    r = row_half ? lane_rot(wk[2], 2) : wk[2];
    s = row_half ? lane_rot(wk[1], 3) : wk[3];
  end

  salsa_qr_lanes u_qr (.p(p), .q(q), .r(r), .s(s), .sub(sub), .upd(upd));

  for (genvar g = 0; g < ROWS; g++) begin : g_ffwd
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign sum[g][l] = wk[g][l] + orig[g][l];
    end
  end

  salsa_unperm u_unperm (.rows(sum), .nat(nat));

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      stp     <= '0;
      rem     <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      blk_out <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          if (cnt_ok) begin
            for (int i = 0; i < ROWS; i++) begin
              wk[i]   <= blk_in[i*ROW_W +: ROW_W];
              orig[i] <= blk_in[i*ROW_W +: ROW_W];
            end
            rem  <= rounds_in;
            stp  <= '0;
            busy <= 1'b1;
            st   <= ST_RUN;
          end else begin
            err <= 1'b1;
          end
        end
        ST_RUN: begin
          if (!row_half) begin
            case (sub)
              2'd0:    wk[1] <= upd;
              2'd1:    wk[2] <= upd;
              2'd2:    wk[3] <= upd;
              default: wk[0] <= upd;
            endcase
          end else begin
            case (sub)
              2'd0:    wk[3] <= lane_rot(upd, 3);
              2'd1:    wk[2] <= lane_rot(upd, 2);
              2'd2:    wk[1] <= lane_rot(upd, 1);
              default: wk[0] <= upd;
            endcase
          end
          stp <= stp + 1'b1;
          if (stp == SW'(STEPS - 1)) begin
            rem <= rem - RW'(2);
            if (rem == RW'(2)) st <= ST_FIN;
          end
        end
        default: begin
          blk_out <= nat;
          done    <= 1'b1;
          busy    <= 1'b0;
          st      <= ST_IDLE;
        end
      endcase
    end
  end

  logic rst_d = 1'b1;
  always_ff @(posedge clk) rst_d <= rst;

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst || rst_d)
    done |=> !done);
  assert_out_hold_R8: assert property (@(posedge clk) disable iff (rst || rst_d)
    !done |-> $stable(blk_out));
  assert_done_idle_R5: assert property (@(posedge clk) disable iff (rst || rst_d)
    done |-> !busy);
  assert_err_quiet_R7: assert property (@(posedge clk) disable iff (rst || rst_d)
    err |-> (!busy && !done));
  assert_busy_start_R6: assert property (@(posedge clk) disable iff (rst || rst_d)
    (busy && start) |=> $stable(orig));
  assert_rem_even_R4: assert property (@(posedge clk) disable iff (rst || rst_d)
    (st == ST_RUN) |-> (rem != '0 && !rem[0]));
endmodule

// File: tb/sim_salsa_lane_core.sv
module sim_salsa_lane_core;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [7:0] rounds_in = '0;
  logic [511:0] blk_in = '0;
  logic busy, done, err;
  logic [511:0] blk_out;
  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  salsa_lane_core u0 (.clk(clk), .rst(rst), .start(start), .rounds_in(rounds_in),
    .blk_in(blk_in), .busy(busy), .done(done), .err(err), .blk_out(blk_out));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog expired act=%0d exp<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rl(input logic [31:0] v, input int n);
    return (v << n) | (v >> (32 - n));
  endfunction

  function automatic logic [511:0] ref_core(input logic [511:0] nat, input int rounds);
    logic [31:0] x[16];
    logic [31:0] z[16];
    logic [511:0] o;
    int y0, y1, y2, y3;
    for (int i = 0; i < 16; i++) begin x[i] = nat[i*32 +: 32]; z[i] = x[i]; end
    for (int d = 0; d < rounds / 2; d++) begin
      for (int h = 0; h < 2; h++) begin
        for (int j = 0; j < 4; j++) begin
          if (h == 0) begin
            y0 = (5*j) % 16; y1 = (5*j+4) % 16; y2 = (5*j+8) % 16; y3 = (5*j+12) % 16;
          end else begin
            y0 = 4*j + j; y1 = 4*j + (j+1)%4; y2 = 4*j + (j+2)%4; y3 = 4*j + (j+3)%4;
          end
          x[y1] = x[y1] ^ rl(x[y0] + x[y3], 7);
          x[y2] = x[y2] ^ rl(x[y1] + x[y0], 9);
          x[y3] = x[y3] ^ rl(x[y2] + x[y1], 13);
          x[y0] = x[y0] ^ rl(x[y3] + x[y2], 18);
        end
      end
    end
    for (int i = 0; i < 16; i++) o[i*32 +: 32] = x[i] + z[i];
    return o;
  endfunction

  // R1 layout: slot 4*row+lane carries natural word (5*lane + 4*row) mod 16
  function automatic logic [511:0] perm_in(input logic [511:0] nat);
    logic [511:0] o;
    for (int r = 0; r < 4; r++)
      for (int j = 0; j < 4; j++)
        o[(4*r+j)*32 +: 32] = nat[((5*j + 4*r) % 16)*32 +: 32];
    return o;
  endfunction

  function automatic logic [511:0] rand_blk();
    logic [511:0] o;
    for (int i = 0; i < 16; i++) o[i*32 +: 32] = $urandom;
    return o;
  endfunction

  task automatic do_run(input logic [511:0] nat, input int rounds, input bit poke, input string tag);
    logic [511:0] exp;
    bit bad;
    int last;
    exp = ref_core(nat, rounds);
    last = 4*rounds + 1;
    bad = 1'b0;
    @(negedge clk);
    blk_in = perm_in(nat); rounds_in = 8'(rounds); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (!busy || done) bad = 1'b1;
    for (int k = 1; k <= last; k++) begin
      if (poke && k == 3) begin start = 1'b1; blk_in = ~blk_in; rounds_in = 8'd2; end
      if (poke && k == 4) start = 1'b0;
      @(negedge clk);
      if (k < last && (!busy || done)) bad = 1'b1;
    end
    chk(!bad, "R5 busy high and done low during run", {511'd0, bad}, 512'd0);
    chk(done && !busy, "R4 done at predicted cycle", {510'd0, done, busy}, 512'd2);
    chk(blk_out == exp, poke ? "R6 start while busy ignored" : tag, blk_out, exp);
    @(negedge clk);
    chk(!done && blk_out == exp, "R8 done one cycle and output held", blk_out, exp);
  endtask

  task automatic do_bad(input int rounds);
    logic [511:0] prev;
    bit seen_done;
    prev = blk_out;
    seen_done = 1'b0;
    @(negedge clk);
    blk_in = rand_blk(); rounds_in = 8'(rounds); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(err && !busy, "R7 err pulse for refused count", {510'd0, err, busy}, 512'd2);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (done || busy || err) seen_done = 1'b1;
    end
    chk(!seen_done && blk_out == prev, "R7 no run and output unchanged", blk_out, prev);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(!busy, "R9 busy cleared", {511'd0, busy}, 512'd0);
    chk(!done, "R9 done cleared", {511'd0, done}, 512'd0);
    chk(!err, "R9 err cleared", {511'd0, err}, 512'd0);
    chk(blk_out == '0, "R9 output cleared", blk_out, 512'd0);
    do_run('0, 2, 1'b0, "R3 two rounds zero block");
    do_run(rand_blk(), 2, 1'b0, "R3 two rounds random");
    do_run('0, 8, 1'b0, "R2 eight rounds zero block");
    do_run(rand_blk(), 8, 1'b0, "R2 eight rounds random");
    do_run(rand_blk(), 12, 1'b0, "R2 twelve rounds random");
    do_run('0, 12, 1'b0, "R2 twelve rounds zero block");
    do_run(rand_blk(), 20, 1'b0, "R2 twenty rounds random");
    do_run('0, 20, 1'b0, "R2 twenty rounds zero block");
    do_run(rand_blk(), 8, 1'b1, "R6");
    do_bad(0);
    do_bad(1);
    do_bad(7);
    do_run({16{32'hffffffff}}, 20, 1'b0, "R1 all-ones layout check");
    // R9 reset after a completed run clears the output again
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(blk_out == '0 && !busy && !done, "R9 reset clears after run", blk_out, 512'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule